// File: doc/BRIEF.md
# Overhead Data-Link Bit Transmitter

This block sends a host-supplied byte, one bit at a time, in the overhead-bit positions of a T1 line. In extended superframe framing those positions carry the data link. In D4 framing they carry the Fs framing bits. The surrounding framer marks each free overhead position with a one-cycle slot strobe. For every strobe the block puts exactly one bit on its serial output, and that output keeps its value until the next strobe.

The host writes bytes into a holding register. At each byte boundary the block copies the holding register into the byte being transmitted. It then raises an empty flag, which can also drive an active-low interrupt if the mask allows it. If the host does not write again, the same byte is copied in at the next boundary and sent once more. For D4 operation the host writes 1Ch. A mode select can restrict loading to byte boundaries that coincide with a multiframe strobe.

Optional zero stuffing follows the rule used by link-access protocols: after five transmitted 1s, a 0 is inserted. The count of 1s carries across byte boundaries. Any transmitted 0 resets it, whether the 0 came from the data or was inserted. An inserted 0 takes one slot, and data transmission pauses for that slot.

Top module: `ovh_link_tx`

## Requirements
- R1: Each byte is sent least significant bit first. `ovhBit` takes a new value only on a clock edge where `slotStrobe` is high, and holds its value between strobes.
- R2: After reset, the holding register and the byte being sent are both 00h, `ovhBit` is 0, `bufEmpty` is 0 and `intN` is 1.
- R3: When the last data bit of a byte is sent and the holding register is copied in at that boundary, `bufEmpty` becomes 1 on the same edge.
- R4: `intN` is 0 exactly when `bufEmpty` is 1 and `intEnable` is 1. Otherwise it is 1.
- R5: A host write updates the holding register and clears `bufEmpty`, which releases `intN`. A write made partway through a byte does not change the rest of that byte. The new value is sent starting with the next byte.
- R6: If the host writes nothing, the same byte is copied in again at the next boundary and sent again unchanged.
- R7: With `stuffEn` at 1, the slot that follows five consecutive transmitted 1s carries an inserted 0. The data bit position does not advance during that slot.
- R8: The count of consecutive 1s carries across byte boundaries. Any transmitted 0, data or inserted, resets it. With `stuffEn` at 0, no 0 is ever inserted.
- R9: With `mfLoadMode` at 1, the holding register is copied in only at a byte boundary where `mfBoundary` is high in the same cycle as the last slot strobe. At any other boundary the current byte is sent again and `bufEmpty` keeps its value.
- R10: When the holding register holds 1Ch, each byte sends the bits 0,0,1,1,1,0,0,0 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Write strobe for the holding register |
| hostWrData | input | 8 | Data for the holding register |
| slotStrobe | input | 1 | Marks one free overhead-bit slot |
| mfBoundary | input | 1 | Multiframe-boundary strobe |
| stuffEn | input | 1 | Enables zero insertion after five 1s |
| intEnable | input | 1 | Interrupt mask: 1 lets the empty flag drive `intN` |
| mfLoadMode | input | 1 | 1 = copy the holding register in only on multiframe boundaries |
| ovhBit | output | 1 | Serial overhead bit |
| bufEmpty | output | 1 | Holding register has been taken and needs a new byte |
| intN | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a stuffed 0 at a byte boundary. It needs five 1s to build up across the end of one byte and the start of the next, so that the inserted slot pushes every later data bit back by one. The bench reaches it by sending 0xFF bytes back to back, and then a byte whose top five bits are 1s. While doing so it runs its own bit-level model of the slot sequence, and it compares every strobed bit against that model. The multiframe gating is reached by holding a new byte through one boundary with no multiframe strobe, then giving the strobe at the next boundary.

// File: rtl/ovh_link_pkg.sv
package ovh_link_pkg;
  // Strobes from control to datapath, one slot at a time
  typedef struct packed {
    logic sendData;   // a data bit occupies this slot
    logic sendStuff;  // an inserted zero occupies this slot
    logic byteEnd;    // last data bit of the byte is sent now
    logic loadHold;   // copy holding register into active byte
  } ctrlStrobes_t;
endpackage

// File: rtl/ovh_link_ctrl.sv
module ovh_link_ctrl
  import ovh_link_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 5,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStrobe,
  input  logic             mfBoundary,
  input  logic             stuffEn,
  input  logic             mfLoadMode,
  input  logic             curBit,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] onesCnt;
  logic             stuffDue;

  assign stuffDue = stuffEn && (onesCnt == RUN_MAX);

  always_comb begin
    strobes.sendStuff = slotStrobe && stuffDue;
    strobes.sendData  = slotStrobe && !stuffDue;
    strobes.byteEnd   = strobes.sendData && (bitIdx == LAST_IDX);
    strobes.loadHold  = strobes.byteEnd && (!mfLoadMode || mfBoundary);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (strobes.sendStuff) begin
        onesCnt <= '0;
      end else if (strobes.sendData) begin
        if (!curBit)                onesCnt <= '0;
        else if (onesCnt < RUN_MAX) onesCnt <= onesCnt + 1'b1;
      end
      if (strobes.sendData) begin
        bitIdx <= strobes.byteEnd ? '0 : bitIdx + 1'b1;
      end
    end
  end

  // R7: an inserted zero does not advance the data position
  p_idx_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sendStuff |=> $stable(bitIdx));

  // R1: without a slot strobe the data position does not move
  p_idx_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !slotStrobe |=> $stable(bitIdx));
endmodule

// File: rtl/ovh_link_dp.sv
module ovh_link_dp
  import ovh_link_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              intEnable,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              curBit,
  output logic              ovhBit,
  output logic              bufEmpty,
  output logic              intN
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] activeByte;

  assign curBit = activeByte[bitIdx];
  assign intN   = !(bufEmpty && intEnable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= '0;
      activeByte <= '0;
      ovhBit     <= 1'b0;
      bufEmpty   <= 1'b0;
    end else begin
      if (hostWrEn)              holdReg    <= hostWrData;
      if (strobes.loadHold)      activeByte <= holdReg;
      if (strobes.sendStuff)     ovhBit     <= 1'b0;
      else if (strobes.sendData) ovhBit     <= curBit;
      if (hostWrEn)              bufEmpty   <= 1'b0;
      else if (strobes.loadHold) bufEmpty   <= 1'b1;
    end
  end

  // R1: the serial bit holds between slots
  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.sendData || strobes.sendStuff) |=> $stable(ovhBit));

  // R5: a write clears the empty flag and releases the interrupt
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> (!bufEmpty && intN));

  // R4: a masked interrupt is never asserted
  p_int_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> intN);
endmodule

// File: rtl/ovh_link_tx.sv
module ovh_link_tx
  import ovh_link_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 5,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              slotStrobe,
  input  logic              mfBoundary,
  input  logic              stuffEn,
  input  logic              intEnable,
  input  logic              mfLoadMode,
  output logic              ovhBit,
  output logic              bufEmpty,
  output logic              intN
);
  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] bitIdx;
  logic             curBit;

  ovh_link_ctrl #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotStrobe (slotStrobe),
    .mfBoundary (mfBoundary),
    .stuffEn    (stuffEn),
    .mfLoadMode (mfLoadMode),
    .curBit     (curBit),
    .strobes    (strb),
    .bitIdx     (bitIdx)
  );

  ovh_link_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .intEnable  (intEnable),
    .strobes    (strb),
    .bitIdx     (bitIdx),
    .curBit     (curBit),
    .ovhBit     (ovhBit),
    .bufEmpty   (bufEmpty),
    .intN       (intN)
  );

  // R7: an inserted slot always puts a zero on the line
  p_stuff_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendStuff |=> !ovhBit);

  // R9: a boundary without a multiframe strobe leaves the empty flag alone
  p_mf_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mfLoadMode && !mfBoundary && strb.byteEnd && !hostWrEn) |=> $stable(bufEmpty));
endmodule

// File: tb/test_ovh_link_tx.sv
module test_ovh_link_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic       slotStrobe = 1'b0;
  logic       mfBoundary = 1'b0;
  logic       stuffEn = 1'b0;
  logic       intEnable = 1'b0;
  logic       mfLoadMode = 1'b0;
  logic       ovhBit, bufEmpty, intN;

  int vectors = 0;
  int fails   = 0;

  // bench model state, built from the requirements
  logic [7:0] mByte = 8'h00, mHold = 8'h00;
  int         mIdx = 0, mOnes = 0;
  logic       mEmpty = 1'b0;

  always #5 clk = ~clk;

  ovh_link_tx i_ovh_link_tx (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .slotStrobe(slotStrobe), .mfBoundary(mfBoundary), .stuffEn(stuffEn),
    .intEnable(intEnable), .mfLoadMode(mfLoadMode),
    .ovhBit(ovhBit), .bufEmpty(bufEmpty), .intN(intN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one slot; returns the bit the model expects
  task automatic slot(input logic mfb, input string req, output logic expBit);
    if (stuffEn && mOnes == 5) begin
      expBit = 1'b0; mOnes = 0;
    end else begin
      expBit = mByte[mIdx];
      mOnes = expBit ? ((mOnes < 5) ? mOnes + 1 : 5) : 0;
      if (mIdx == 7) begin
        mIdx = 0;
        if (!mfLoadMode || mfb) begin mByte = mHold; mEmpty = 1'b1; end
      end else mIdx++;
    end
    @(negedge clk); slotStrobe = 1'b1; mfBoundary = mfb;
    @(negedge clk); slotStrobe = 1'b0; mfBoundary = 1'b0;
    check(req, ovhBit, expBit);
    check(req, bufEmpty, mEmpty);
    check("R4", intN, !(mEmpty && intEnable));
  endtask

  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
    mHold = d; mEmpty = 1'b0;
    check("R5", bufEmpty, 1'b0);
    check("R5", intN, 1'b1);
  endtask

  task automatic runSlots(input int n, input string req);
    logic b;
    for (int i = 0; i < n; i++) slot(1'b0, req, b);
  endtask

  task automatic testReset();
    check("R2", ovhBit, 1'b0);
    check("R2", bufEmpty, 1'b0);
    check("R2", intN, 1'b1);
    runSlots(8, "R2");  // reset byte is 00h
  endtask

  task automatic testOrder();
    logic b;
    logic [7:0] seen;
    hostWrite(8'hA5);
    runSlots(8, "R3");          // 00h repeats, A5 taken at the end
    check("R3", bufEmpty, 1'b1);
    check("R4", intN, 1'b1);    // masked
    @(negedge clk); intEnable = 1'b1;
    @(negedge clk); check("R4", intN, 1'b0);
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R1", b); seen[i] = ovhBit; end
    check("R1", seen == 8'hA5, 1'b1);
    repeat (4) @(negedge clk);
    check("R1", ovhBit, 1'b1);  // last bit of A5 held between slots
  endtask

  task automatic testRepeat();
    logic b;
    logic [7:0] seen;
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R6", b); seen[i] = ovhBit; end
    check("R6", seen == 8'hA5, 1'b1);
  endtask

  task automatic testMidWrite();
    logic b;
    logic [7:0] seen;
    runSlots(3, "R5");
    hostWrite(8'h3C);
    for (int i = 3; i < 8; i++) begin slot(1'b0, "R5", b); seen[i] = ovhBit; end
    check("R5", seen[7:3] == 5'b10100, 1'b1);  // rest of A5
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R5", b); seen[i] = ovhBit; end
    check("R5", seen == 8'h3C, 1'b1);
  endtask

  task automatic testStuff();
    logic b;
    int ones, zeros;
    @(negedge clk); stuffEn = 1'b1;
    hostWrite(8'hFF);
    runSlots(8, "R7");                    // 3C drains, FF taken
    ones = 0; zeros = 0;
    for (int i = 0; i < 20; i++) begin    // FF FF with stuffing across the boundary
      slot(1'b0, "R7", b);
      if (ovhBit) ones++; else zeros++;
    end
    check("R7", zeros >= 3, 1'b1);
    hostWrite(8'hF8);                     // five 1s in the top bits
    runSlots(20, "R8");
    hostWrite(8'h07);
    runSlots(24, "R8");
    @(negedge clk); stuffEn = 1'b0;
    hostWrite(8'hFF);
    runSlots(24, "R8");
    ones = 0;
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R8", b); if (ovhBit) ones++; end
    check("R8", ones == 8, 1'b1);         // no insertion when disabled
  endtask

  task automatic testMf();
    logic b;
    logic [7:0] seen;
    hostWrite(8'h1C);
    runSlots(8 - mIdx, "R9");           // finish current byte, takes 1C
    @(negedge clk); mfLoadMode = 1'b1;
    hostWrite(8'h55);
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R10", b); seen[i] = ovhBit; end
    check("R10", seen == 8'h1C, 1'b1);
    check("R9", bufEmpty, 1'b0);         // boundary without strobe: held
    for (int i = 0; i < 7; i++) begin slot(1'b0, "R9", b); seen[i] = ovhBit; end
    slot(1'b1, "R9", b); seen[7] = ovhBit;
    check("R9", seen == 8'h1C, 1'b1);    // repeated
    check("R9", bufEmpty, 1'b1);
    for (int i = 0; i < 8; i++) begin slot(1'b0, "R9", b); seen[i] = ovhBit; end
    check("R9", seen == 8'h55, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrder();
    testRepeat();
    testMidWrite();
    testStuff();
    testMf();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule